// File: doc/BRIEF.md
# Signed Array Multiplier with Sign-Magnitude Wrapping

This block multiplies two small two's-complement integers using purely combinational logic. Each operand is first turned into its magnitude by a conditional negator, and the operand's own sign bit controls that negator. The two magnitudes go into an unsigned array multiplier. The array forms every partial-product bit at once with AND gates and sums the rows through a grid of one-bit full-adder cells; it contains no multiply operator.

The unsigned result is padded with zeros on the left up to the product width. A second conditional negator then turns it back into two's complement. That negator is controlled by the product sign, which is the exclusive-OR of the two operand signs. The most negative operand value (all magnitude bits zero with the sign set) is outside the supported range, because its magnitude needs one bit more than the array has.

The block sits in a datapath wherever a single-cycle signed product is needed. It has no clock and no state.

Top module: `signed_array_mul`

## Requirements
- R1: For every pair of operands in the range -31 to +31, `product` equals the signed product of `op_a` and `op_b` as a 12-bit two's-complement value.
- R2: Whenever the product is nonzero, bit 11 of `product` equals bit 5 of `op_a` XOR bit 5 of `op_b`.
- R3: When either operand is zero, `product` is all zeros, even when the two operand sign bits differ (for example 0 times -5).
- R4: Bits 11 and 10 of `product` are always equal, because the largest magnitude (31 x 31 = 961) fits in 10 bits.
- R5: The extreme pairs give exact results: 31 x 31 = 961, -31 x 31 = -961, 31 x -31 = -961 and -31 x -31 = 961.
- R6: Multiplying by +1 returns the other operand sign-extended to 12 bits, and multiplying by -1 returns its negation.
- R7: The output depends only on the present inputs. A change of operands shows on `product` within the same clock period, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 6 | First operand, two's complement, range -31..+31 |
| op_b | input | 6 | Second operand, two's complement, range -31..+31 |
| product | output | 12 | Signed product, two's complement |

## Verification
The bench builds the block with its default operand width of 6. At that width the whole legal operand square of 63 x 63 pairs can be driven exhaustively, one pair per clock. Every sign combination, every zero row and column, and every carry pattern through the full-adder grid is therefore compared against an integer reference. Named cases for the extremes, the unit multipliers and zero with a negative partner are checked on top of the sweep.

// File: rtl/mul_pkg.sv
package mul_pkg;
    // default two's-complement operand width shared by the multiplier tree
    localparam int unsigned OPW_DEFAULT = 6;

    // width of the unsigned magnitude handled by the array core
    function automatic int unsigned mag_width(input int unsigned opw);
        return opw - 1;
    endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic hx;

    assign hx = x ^ y;
    assign s  = hx ^ ci;
    assign co = (x & y) | (ci & hx);
endmodule

// File: rtl/cond_negate.sv
module cond_negate #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] din,
    input  logic         neg,
    output logic [N-1:0] dout
);
    // invert under control, then ripple an increment of 'neg' through half adders
    logic [N-1:0] inv;
    logic [N:0]   carry;

    assign inv      = din ^ {N{neg}};
    assign carry[0] = neg;

    for (genvar k = 0; k < N; k++) begin : g_inc
        assign dout[k]    = inv[k] ^ carry[k];
        assign carry[k+1] = inv[k] & carry[k];
    end
endmodule

// File: rtl/uarray_core.sv
module uarray_core #(
    parameter int unsigned M = 5
) (
    input  logic [M-1:0]   xa,
    input  logic [M-1:0]   xb,
    output logic [2*M-1:0] p
);
    // acc[i]: running sum after row i, M+1 bits; bit 0 retires as product bit i
    logic [M:0]   acc [M];
    logic [M-1:0] pp  [M];

    for (genvar i = 0; i < M; i++) begin : g_pp
        assign pp[i] = xa & {M{xb[i]}};
    end

    assign acc[0] = {1'b0, pp[0]};

    for (genvar i = 1; i < M; i++) begin : g_row
        logic [M:0] cy;
        assign cy[0] = 1'b0;
        for (genvar j = 0; j < M; j++) begin : g_col
            fa_cell u_fa (
                .x  (acc[i-1][j+1]),
                .y  (pp[i][j]),
                .ci (cy[j]),
                .s  (acc[i][j]),
                .co (cy[j+1])
            );
        end
        assign acc[i][M] = cy[M];
        assign p[i-1]    = acc[i-1][0];
    end

    assign p[2*M-1:M-1] = acc[M-1];
endmodule

// File: rtl/signed_array_mul.sv
module signed_array_mul #(
    parameter int unsigned W = mul_pkg::OPW_DEFAULT
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    localparam int unsigned M  = mul_pkg::mag_width(W);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned UW = 2 * M;

    logic         sgn_a;
    logic         sgn_b;
    logic         sgn_p;
    logic [M-1:0] mag_a;
    logic [M-1:0] mag_b;
    logic [UW-1:0] umag;
    logic [PW-1:0] uwide;

    assign sgn_a = op_a[W-1];
    assign sgn_b = op_b[W-1];
    assign sgn_p = sgn_a ^ sgn_b;

    cond_negate #(.N(M)) u_neg_a (
        .din  (op_a[M-1:0]),
        .neg  (sgn_a),
        .dout (mag_a)
    );

    cond_negate #(.N(M)) u_neg_b (
        .din  (op_b[M-1:0]),
        .neg  (sgn_b),
        .dout (mag_b)
    );

    uarray_core #(.M(M)) u_core (
        .xa (mag_a),
        .xb (mag_b),
        .p  (umag)
    );

    assign uwide = {{(PW-UW){1'b0}}, umag};

    cond_negate #(.N(PW)) u_neg_p (
        .din  (uwide),
        .neg  (sgn_p),
        .dout (product)
    );
endmodule

// File: rtl/signed_array_mul_chk.sv
module signed_array_mul_chk #(
    parameter int unsigned W = 6
) (
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-1:0] product
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic                  legal;
    logic signed [2*W-1:0] want;

    always_comb begin
        legal = (op_a != MOST_NEG) && (op_b != MOST_NEG);
        want  = $signed(op_a) * $signed(op_b);
        if (legal) begin
            assert_full_product_R1: assert (product == want)
                else $error("R1 product mismatch");
            if (product != '0) begin
                assert_sign_xor_R2: assert (product[2*W-1] == (op_a[W-1] ^ op_b[W-1]))
                    else $error("R2 sign mismatch");
            end
            if (op_a == '0 || op_b == '0) begin
                assert_zero_clean_R3: assert (product == '0)
                    else $error("R3 zero not clean");
            end
            assert_top_bits_R4: assert (product[2*W-1] == product[2*W-2])
                else $error("R4 top bits differ");
        end
    end
endmodule

bind signed_array_mul signed_array_mul_chk #(.W(W)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/signed_array_mul_test.sv
module signed_array_mul_test;
    localparam int W = 6;

    logic              clk;
    logic [W-1:0]      op_a;
    logic [W-1:0]      op_b;
    logic [2*W-1:0]    product;
    int                checks;
    int                errors;
    bit                done;

    signed_array_mul #(.W(W)) uut (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag,
                     $signed(act), $signed(exp));
        end
    endtask

    // drive just after a rising edge, compare at the following falling edge
    task automatic apply(input int a, input int b);
        @(posedge clk);
        #1;
        op_a = W'(a);
        op_b = W'(b);
        @(negedge clk);
    endtask

    function automatic logic [2*W-1:0] ref_mul(input int a, input int b);
        return (2*W)'(a * b);
    endfunction

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        op_a   = '0;
        op_b   = '0;

        // idle state: zero inputs give zero out (R3)
        apply(0, 0);
        check("R3 idle zero", product, '0);

        // R3: zero against a negative partner, both orders
        apply(0, -5);
        check("R3 zero x -5", product, '0);
        apply(-17, 0);
        check("R3 -17 x zero", product, '0);

        // R5: extremes
        apply(31, 31);
        check("R5 31x31", product, 12'd961);
        apply(-31, 31);
        check("R5 -31x31", product, ref_mul(-961, 1));
        apply(31, -31);
        check("R5 31x-31", product, ref_mul(-961, 1));
        apply(-31, -31);
        check("R5 -31x-31", product, 12'd961);

        // R6: unit multipliers
        apply(1, -23);
        check("R6 1x-23", product, ref_mul(-23, 1));
        apply(-1, -23);
        check("R6 -1x-23", product, ref_mul(23, 1));
        apply(19, -1);
        check("R6 19x-1", product, ref_mul(-19, 1));

        // R7: input change seen in the same period, back and forth
        apply(7, 9);
        check("R7 first value", product, ref_mul(7, 9));
        #0.5;
        op_a = W'(-7);
        #0.5;
        check("R7 same period", product, ref_mul(-7, 9));

        // R1, R2, R4: exhaustive sweep, one pair per clock
        for (int a = -31; a <= 31; a++) begin
            for (int b = -31; b <= 31; b++) begin
                apply(a, b);
                check("R1 sweep", product, ref_mul(a, b));
                if (a * b != 0)
                    check("R2 sign", {11'd0, product[2*W-1]},
                          {11'd0, 1'((a < 0) ^ (b < 0))});
                check("R4 top bits", {11'd0, product[2*W-1] ^ product[2*W-2]}, '0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule